// File: doc/BRIEF.md
# Indirect Register Access Bridge

This bridge lets a host with a small direct register window reach a much larger bank of internal registers. The host loads up to four 16-bit staging words, then writes an address word. That one write starts the transaction, so there is no separate start bit. The address word names the target register by a functional block kind, an instance of that kind and a parameter slot. Bit 7 of the word picks the direction.

A write transaction stores all four staging words into the 64-bit target register in a single access. A read transaction fetches the 64-bit target and copies one 16-bit slice, chosen by the two low address bits, into staging word 0. A status flag stays high while a transaction is in flight. An address write that arrives during that time is discarded and raises a sticky error flag. The internal blocks are modelled as one register file, written so that it can map onto block RAM.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, status, the address register and all four staging words read 0, and `host_rvalid` is low.
- R2: A host read (`host_valid`=1, `host_write`=0) returns its data on `host_rdata`, with `host_rvalid` high, in the cycle after the request. Every request gets exactly one response. `host_ready` is always 1.
- R3: Direct window offsets: status at 0x10 (bit 0 = busy, bit 1 = error), address at 0x30, staging words 0 to 3 at 0x40, 0x50, 0x60 and 0x70. An accepted address write raises busy for exactly BUSY_CYCLES cycles, starting the cycle after the write.
- R4: An address write while busy is ignored. The address register, the running transaction and its completion time stay unchanged, and status bit 1 is set. Bit 1 stays set until the host writes status with bit 1 = 1.
- R5: Address word fields: kind in bits 15:12, instance in bits 11:8, direction in bit 7 (0 = write), parameter in bits 3:2. A write transaction stores the 64-bit value {word3, word2, word1, word0} into the target register.
- R6: A read transaction (bit 7 = 1) places the 16-bit slice selected by bits 1:0 (0 = bits 15:0, up to 3 = bits 63:48) into staging word 0 when busy drops. Staging words 1 to 3 are unchanged.
- R7: Kind codes 1 (DMA port), 2 (clock generator), 3 (timer) and 9 (global DMA control) each address separate storage. With any other kind code, a write is dropped and a read returns 0.
- R8: Instance numbers at or above 2^INST_BITS behave like an unsupported kind. A write with such an instance does not alias onto any valid instance.
- R9: Every distinct (kind, instance, parameter) triple holds its own value. Writing one triple leaves the others unchanged.
- R10: A host write to an offset outside the window changes no register, and a read of such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Request accepted (always 1) |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Byte offset in the direct window |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after the request |

## Verification
The bench builds the bridge with BUSY_CYCLES = 3 and INST_BITS = 2. The short busy window lets back-to-back status polls walk the whole busy interval. It also lets a second address write land inside that window. With only four instances, instance codes 4 and 5 fall out of range. Instance 5 shares its low bits with a register the bench has already written, so an aliasing write would show up on readback. Multi-word readback is exercised on four distinct kinds, across all four slice indices.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam logic [7:0] OFF_STATUS = 8'h10;
  localparam logic [7:0] OFF_IADDR  = 8'h30;
  localparam logic [7:0] OFF_DATA0  = 8'h40;
  localparam int         NWORDS     = 4;

  localparam logic [3:0] KIND_DMA    = 4'h1;
  localparam logic [3:0] KIND_CLKGEN = 4'h2;
  localparam logic [3:0] KIND_TIMER  = 4'h3;
  localparam logic [3:0] KIND_GDMA   = 4'h9;

  typedef struct packed {
    logic [3:0] kind;
    logic [3:0] inst;
    logic       rd;
    logic [2:0] rsvd;
    logic [1:0] param;
    logic [1:0] widx;
  } iaddr_t;
endpackage

// File: rtl/ibr_decode.sv
module ibr_decode #(
  parameter int INST_BITS = 3,
  localparam int IDX_W = 2 + INST_BITS + 2
) (
  input  ibr_pkg::iaddr_t   a,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  import ibr_pkg::*;
  localparam int NUM_INST = 1 << INST_BITS;

  logic [1:0] slot;
  logic       kind_ok;
  logic       inst_ok;

  always_comb begin
    kind_ok = 1'b1;
    unique case (a.kind)
      KIND_DMA:    slot = 2'd0;
      KIND_CLKGEN: slot = 2'd1;
      KIND_TIMER:  slot = 2'd2;
      KIND_GDMA:   slot = 2'd3;
      default: begin slot = 2'd0; kind_ok = 1'b0; end
    endcase
    inst_ok = ({1'b0, a.inst} < 5'(NUM_INST));
    hit = kind_ok && inst_ok;
    idx = {slot, a.inst[INST_BITS-1:0], a.param};
  end
endmodule

// File: rtl/ibr_regfile.sv
module ibr_regfile #(
  parameter int IDX_W = 7,
  parameter int DW    = 64
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq #(
  parameter int BUSY_CYCLES = 4,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  output logic busy,
  output logic accept,
  output logic go,
  output logic done
);
  logic [CW-1:0] cnt;

  assign accept = start_req && !busy;
  assign done   = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      go   <= 1'b0;
    end else begin
      go <= accept;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= CW'(BUSY_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int BUSY_CYCLES = 4,
  parameter int INST_BITS   = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_valid,
  output logic        host_ready,
  input  logic        host_write,
  input  logic [7:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        host_rvalid
);
  import ibr_pkg::*;
  localparam int IDX_W = 2 + INST_BITS + 2;
  localparam int DW    = 16 * NWORDS;

  iaddr_t           iar_q;
  logic [15:0]      dreg [NWORDS];
  logic             err_q;
  logic             busy, accept, go, done;
  logic             hit, hit_q, op_rd_q;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    rf_q;
  logic [DW-1:0]    wide_w;
  logic [15:0]      slice;

  logic wr_req, rd_req, iar_wr, st_wr;
  assign wr_req = host_valid && host_write;
  assign rd_req = host_valid && !host_write;
  assign iar_wr = wr_req && (host_addr == OFF_IADDR);
  assign st_wr  = wr_req && (host_addr == OFF_STATUS);
  assign host_ready = 1'b1;

  ibr_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start_req(iar_wr),
    .busy(busy), .accept(accept), .go(go), .done(done)
  );

  ibr_decode #(.INST_BITS(INST_BITS)) u_dec (
    .a(iar_q), .hit(hit), .idx(idx)
  );

  genvar w;
  generate
    for (w = 0; w < NWORDS; w++) begin : g_wide
      assign wide_w[16*w +: 16] = dreg[w];
    end
  endgenerate

  ibr_regfile #(.IDX_W(IDX_W), .DW(DW)) u_rf (
    .clk(clk), .we(go && !iar_q.rd && hit), .re(go && iar_q.rd),
    .idx(idx), .wdata(wide_w), .rdata(rf_q)
  );

  assign slice = hit_q ? rf_q[16*iar_q.widx +: 16] : 16'h0000;

  always_ff @(posedge clk) begin
    if (rst) begin
      iar_q   <= '0;
      err_q   <= 1'b0;
      hit_q   <= 1'b0;
      op_rd_q <= 1'b0;
      for (int i = 0; i < NWORDS; i++) dreg[i] <= '0;
    end else begin
      if (accept) iar_q <= iaddr_t'(host_wdata);
      if (go) begin
        hit_q   <= hit;
        op_rd_q <= iar_q.rd;
      end
      if (iar_wr && busy)               err_q <= 1'b1;
      else if (st_wr && host_wdata[1])  err_q <= 1'b0;
      for (int i = 0; i < NWORDS; i++) begin
        if (i == 0 && done && op_rd_q)
          dreg[i] <= slice;
        else if (wr_req && host_addr == OFF_DATA0 + 8'(16 * i))
          dreg[i] <= host_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_req;
      if (rd_req) begin
        host_rdata <= '0;
        if (host_addr == OFF_STATUS) host_rdata <= {14'h0, err_q, busy};
        if (host_addr == OFF_IADDR)  host_rdata <= iar_q;
        for (int i = 0; i < NWORDS; i++)
          if (host_addr == OFF_DATA0 + 8'(16 * i)) host_rdata <= dreg[i];
      end
    end
  end
endmodule

// File: rtl/ibr_checker.sv
module ibr_checker #(
  parameter int BUSY_CYCLES = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        host_valid,
  input logic        host_write,
  input logic [7:0]  host_addr,
  input logic [15:0] host_wdata,
  input logic        host_rvalid,
  input logic        busy,
  input logic        err,
  input logic [15:0] iar_q
);
  logic [15:0] run;
  logic        aw;
  assign aw = host_valid && host_write && host_addr == 8'h30;

  always_ff @(posedge clk) begin
    if (rst)       run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  // R3: busy never outlasts its window
  p_busy_max_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run < 16'(BUSY_CYCLES)));
  // R3: busy is not cut short
  p_busy_full_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && run < 16'(BUSY_CYCLES - 1)) |=> busy);
  // R3: an address write while idle starts a transaction
  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (aw && !busy) |=> busy);
  // R4: a colliding address write raises the error flag
  p_err_set_r4: assert property (@(posedge clk) disable iff (rst)
    (aw && busy) |=> err);
  // R4: the error flag is sticky until cleared
  p_err_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (err && !(host_valid && host_write && host_addr == 8'h10 && host_wdata[1])) |=> err);
  // R4: the address register holds while busy
  p_iar_hold_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(iar_q));
  // R2: every read request is answered in the next cycle
  p_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    (host_valid && !host_write) |=> host_rvalid);
endmodule

bind ind_reg_bridge ibr_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .host_valid(host_valid), .host_write(host_write),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
  .busy(busy), .err(err_q), .iar_q(iar_q)
);

// File: tb/ind_reg_bridge_bench.sv
module ind_reg_bridge_bench;
  localparam int BUSY = 3;
  localparam int IB   = 2;
  localparam logic [7:0] A_ST = 8'h10, A_IA = 8'h30, A_D0 = 8'h40,
                         A_D1 = 8'h50, A_D2 = 8'h60, A_D3 = 8'h70;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic host_ready, host_rvalid;
  logic [15:0] host_rdata;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  ind_reg_bridge #(.BUSY_CYCLES(BUSY), .INST_BITS(IB)) u_ind_reg_bridge (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  // monitor: compare each response against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected response: actual %h expected none", host_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (host_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, host_rdata, e);
        end
      end
    end
  end

  task automatic hwr(input logic [7:0] a, input logic [15:0] d);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    host_valid = 1'b1; host_write = 1'b0; host_addr = a;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stage(input logic [15:0] w0, w1, w2, w3);
    hwr(A_D0, w0); hwr(A_D1, w1); hwr(A_D2, w2); hwr(A_D3, w3);
  endtask

  task automatic xact(input logic [15:0] aw);
    hwr(A_IA, aw);
    idle(BUSY + 1);
  endtask

  task automatic rdword(input logic [15:0] reg_a, input logic [1:0] ix,
                        input logic [15:0] e, input string t);
    xact(reg_a | 16'h0080 | {14'h0, ix});
    hrd(A_D0, e, t);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    idle(3);
    rst = 1'b0;
    idle(1);
    checks++;
    if (host_rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rvalid: actual %b expected 0", host_rvalid);
    end
    // R1 reset values
    hrd(A_ST, 16'h0, "R1 status");
    hrd(A_IA, 16'h0, "R1 address");
    hrd(A_D0, 16'h0, "R1 word0");
    hrd(A_D3, 16'h0, "R1 word3");

    // R3 busy window, R5 write of kind 1 inst 1 param 1
    stage(16'h1111, 16'h2222, 16'h3333, 16'h4444);
    hwr(A_IA, 16'h1104);
    hrd(A_ST, 16'h1, "R3 busy c1");
    hrd(A_ST, 16'h1, "R3 busy c2");
    hrd(A_ST, 16'h1, "R3 busy c3");
    hrd(A_ST, 16'h0, "R3 idle c4");
    hrd(A_IA, 16'h1104, "R3 address held");

    // R6 readback of all four slices
    rdword(16'h1104, 2'd0, 16'h1111, "R6 slice0");
    rdword(16'h1104, 2'd1, 16'h2222, "R6 slice1");
    rdword(16'h1104, 2'd2, 16'h3333, "R6 slice2");
    rdword(16'h1104, 2'd3, 16'h4444, "R6 slice3");
    hrd(A_D1, 16'h2222, "R6 word1 untouched");
    hrd(A_D3, 16'h4444, "R6 word3 untouched");

    // R7/R9 other kinds
    stage(16'h9a00, 16'h9a01, 16'h9a02, 16'h9a03); xact(16'h900C);
    stage(16'h2b00, 16'h2b01, 16'h2b02, 16'h2b03); xact(16'h2300);
    stage(16'h3c00, 16'h3c01, 16'h3c02, 16'h3c03); xact(16'h3008);
    rdword(16'h900C, 2'd2, 16'h9a02, "R7 kind9");
    rdword(16'h2300, 2'd1, 16'h2b01, "R7 kind2");
    rdword(16'h3008, 2'd3, 16'h3c03, "R7 kind3");
    rdword(16'h1104, 2'd0, 16'h1111, "R9 kind1 intact");

    // R7 unsupported kind
    stage(16'h5555, 16'h5556, 16'h5557, 16'h5558); xact(16'h5104);
    rdword(16'h5104, 2'd0, 16'h0000, "R7 unsupported kind reads 0");
    rdword(16'h1104, 2'd1, 16'h2222, "R7 no alias from kind5");

    // R8 instance out of range
    stage(16'h7770, 16'h7771, 16'h7772, 16'h7773); xact(16'h1504);
    rdword(16'h1404, 2'd0, 16'h0000, "R8 inst4 reads 0");
    rdword(16'h1104, 2'd2, 16'h3333, "R8 inst5 no alias onto inst1");

    // R4 collision
    stage(16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD);
    hwr(A_IA, 16'h2104);
    hwr(A_IA, 16'h1184);
    hrd(A_ST, 16'h3, "R4 err+busy c2");
    hrd(A_ST, 16'h3, "R4 err+busy c3");
    hrd(A_ST, 16'h2, "R4 original end c4");
    hrd(A_IA, 16'h2104, "R4 address unchanged");
    hrd(A_D0, 16'hAAAA, "R4 ignored read not run");
    hwr(A_ST, 16'h0002);
    hrd(A_ST, 16'h0, "R4 error cleared");
    rdword(16'h2104, 2'd3, 16'hDDDD, "R4 first write landed");

    // R10 writes outside the window
    hwr(8'h20, 16'hFFFF);
    hwr(8'h44, 16'hFFFF);
    hwr(8'h80, 16'hFFFF);
    hrd(A_D0, 16'hDDDD, "R10 word0 unchanged");
    hrd(A_D2, 16'hCCCC, "R10 word2 unchanged");
    hrd(A_ST, 16'h0, "R10 status unchanged");
    hrd(8'h20, 16'h0, "R10 unmapped read 0");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses: actual %0d expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule